// File: doc/BRIEF.md
# Bit-Serial Three-Register ALU

This block is the arithmetic core of a very small processor that works one bit at a time. It keeps three word-wide working registers and one carry flip-flop. An operation reads the low bit of register 0 and register 1 on each enabled clock and produces one result bit. That bit is written into the top bit of the chosen destination register, while every register rotates right by one position. After as many enabled clocks as the word has bits, every register is back in its original alignment. The destination then holds the full result, and the carry flip-flop holds the final carry.

A controller pulses `start` with an operation code, a destination select and a carry-in value. It then keeps the clock enable high for the remaining bit cycles and waits for `done`. Operands are loaded by streaming them in through `ser_in` with the load operation. The low bit of register 2 is always visible on `ser_out`. A debug read port, present when the `DEBUG_EN` parameter is set, shows any register or the carry flag in parallel. The word width is a parameter, and a 16-bit build uses the same structure.

Top module: `serial_alu3`

## Requirements
- R1: Operation code 0 (add) leaves (reg0 + reg1 + carry_in) mod 2^WIDTH in the destination. `carry_out` shows the carry out of the top bit.
- R2: Operation code 1 (subtract) computes reg0 + ~reg1 + carry_in. With carry_in = 1 the destination receives reg0 - reg1 mod 2^WIDTH, and `carry_out` is 1 exactly when reg0 >= reg1.
- R3: Operation codes 2 (AND), 3 (OR), 4 (XOR) and 5 (copy reg0) write the bitwise result into the destination, and `carry_out` equals the carry_in given at start. Code 6 loads `ser_in`, sampled in bit cycle i, into bit i. Code 7, or destination select 3, writes no register.
- R4: Every register that is not the destination holds its pre-operation value again when `done` rises.
- R5: `done` rises after exactly WIDTH enabled cycles, the start cycle included. It stays high until the next accepted start and is never high while an operation is in progress.
- R6: While `ce` is low, the registers, the carry flag, the bit count and `done` all hold, and the cycle does not count as a bit cycle.
- R7: With `ce` high and no operation in progress or starting, all three registers rotate right by one bit per cycle and the carry flag holds.
- R8: A `start` while an operation is in progress is ignored, together with the operation code and destination presented with it.
- R9: `dbg_sel` 0, 1 or 2 shows register 0, 1 or 2 on `dbg_word`. `dbg_sel` 3 shows the carry flag in bit 0 with zeros above.
- R10: `ser_out` always equals bit 0 of register 2.
- R11: After reset, all registers are zero, the carry flag is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; each high cycle is one bit step |
| start | input | 1 | Begins an operation; also processes bit 0 |
| op | input | 3 | Operation code, sampled at start |
| dst_sel | input | 2 | Destination register 0..2; 3 = none |
| carry_in | input | 1 | Carry into bit 0 |
| ser_in | input | 1 | Serial data for the load operation |
| ser_out | output | 1 | Low bit of register 2 |
| done | output | 1 | Operation complete |
| carry_out | output | 1 | Carry flag |
| dbg_sel | input | 2 | Debug read select |
| dbg_word | output | WIDTH | Debug read data |

## Verification
The bench builds the block with WIDTH = 8 and DEBUG_EN = 1. The debug port then exposes all three registers on every clock, and an 8-bit word makes the wrap and borrow corners cheap to reach: 0xFF + 0x01, 0x10 - 0x20 and equal operands. With eight bit steps per operation, the bench can place clock-enable gaps and a stray start at chosen bit positions. It can also run a partial idle rotation and then the remaining steps needed to realign the registers.

// File: rtl/serial_alu3_pkg.sv
package serial_alu3_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_PASS = 3'd5,
      OP_LOAD = 3'd6,
      OP_NOP  = 3'd7
   } alu_op_e;

   localparam int NUM_REGS = 3;
   localparam int SEL_W    = 2;
endpackage

// File: rtl/serial_alu3_bitcell.sv
module serial_alu3_bitcell
   import serial_alu3_pkg::*;
(
   input  alu_op_e op,
   input  logic    a,
   input  logic    b,
   input  logic    ser,
   input  logic    cin,
   output logic    res,
   output logic    cout,
   output logic    wr
);
   logic b_eff;
   logic sum;
   logic cgen;

   always_comb begin
      b_eff = (op == OP_SUB) ? ~b : b;
      sum   = a ^ b_eff ^ cin;
      cgen  = (a & b_eff) | (cin & (a ^ b_eff));
      wr    = (op != OP_NOP);
      cout  = cin;
      res   = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB: begin
            res  = sum;
            cout = cgen;
         end
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_PASS: res = a;
         OP_LOAD: res = ser;
         default: res = 1'b0;
      endcase
   end
endmodule

// File: rtl/serial_alu3_seq.sv
module serial_alu3_seq
   import serial_alu3_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             start,
   input  alu_op_e          op_in,
   input  logic [SEL_W-1:0] dst_in,
   output logic             step,
   output logic             first,
   output alu_op_e          op_eff,
   output logic [SEL_W-1:0] dst_eff,
   output logic             busy,
   output logic             done
);
   localparam int CW = $clog2(WIDTH + 1);

   logic [CW-1:0]    cnt_q;
   logic [CW-1:0]    cnt_nx;
   alu_op_e          op_q;
   logic [SEL_W-1:0] dst_q;
   logic             busy_q;
   logic             done_q;

   always_comb begin
      first   = ce & start & ~busy_q;
      step    = ce & (busy_q | first);
      op_eff  = first ? op_in  : op_q;
      dst_eff = first ? dst_in : dst_q;
      cnt_nx  = first ? CW'(1) : cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         op_q   <= OP_NOP;
         dst_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (step) begin
         if (first) begin
            op_q  <= op_in;
            dst_q <= dst_in;
         end
         if (cnt_nx == CW'(WIDTH)) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_nx;
            busy_q <= 1'b1;
            done_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/serial_alu3_regfile.sv
module serial_alu3_regfile
   import serial_alu3_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int NREGS = NUM_REGS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ce,
   input  logic                        wr_en,
   input  logic [SEL_W-1:0]            dst,
   input  logic                        res,
   output logic [NREGS-1:0][WIDTH-1:0] q
);
   for (genvar k = 0; k < NREGS; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[k] <= '0;
         end else if (ce) begin
            if (wr_en && (dst == SEL_W'(k))) begin
               q[k] <= {res, q[k][WIDTH-1:1]};
            end else begin
               q[k] <= {q[k][0], q[k][WIDTH-1:1]};
            end
         end
      end
   end
endmodule

// File: rtl/serial_alu3.sv
module serial_alu3
   import serial_alu3_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int DEBUG_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             start,
   input  logic [2:0]       op,
   input  logic [1:0]       dst_sel,
   input  logic             carry_in,
   input  logic             ser_in,
   output logic             ser_out,
   output logic             done,
   output logic             carry_out,
   input  logic [1:0]       dbg_sel,
   output logic [WIDTH-1:0] dbg_word
);
   localparam int NREGS = NUM_REGS;

   if (WIDTH < 2) begin : g_bad_width
      $error("serial_alu3: WIDTH must be at least 2");
   end
   if (DEBUG_EN != 0 && DEBUG_EN != 1) begin : g_bad_dbg
      $error("serial_alu3: DEBUG_EN must be 0 or 1");
   end

   logic                        step_w;
   logic                        first_w;
   alu_op_e                     op_w;
   logic [SEL_W-1:0]            dst_w;
   logic                        busy_w;
   logic                        res_w;
   logic                        cout_w;
   logic                        wr_op_w;
   logic                        wr_en_w;
   logic                        cin_w;
   logic                        carry_q;
   logic [NREGS-1:0][WIDTH-1:0] rq;
   logic [WIDTH-1:0]            r0_w;
   logic [WIDTH-1:0]            r1_w;
   logic [WIDTH-1:0]            r2_w;

   serial_alu3_seq #(.WIDTH(WIDTH)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce      (ce),
      .start   (start),
      .op_in   (alu_op_e'(op)),
      .dst_in  (dst_sel),
      .step    (step_w),
      .first   (first_w),
      .op_eff  (op_w),
      .dst_eff (dst_w),
      .busy    (busy_w),
      .done    (done)
   );

   assign cin_w = first_w ? carry_in : carry_q;

   serial_alu3_bitcell u_cell (
      .op   (op_w),
      .a    (rq[0][0]),
      .b    (rq[1][0]),
      .ser  (ser_in),
      .cin  (cin_w),
      .res  (res_w),
      .cout (cout_w),
      .wr   (wr_op_w)
   );

   assign wr_en_w = step_w & wr_op_w;

   serial_alu3_regfile #(.WIDTH(WIDTH), .NREGS(NREGS)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .wr_en (wr_en_w),
      .dst   (dst_w),
      .res   (res_w),
      .q     (rq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
      end else if (step_w) begin
         carry_q <= cout_w;
      end
   end

   assign r0_w      = rq[0];
   assign r1_w      = rq[1];
   assign r2_w      = rq[2];
   assign ser_out   = rq[2][0];
   assign carry_out = carry_q;

   if (DEBUG_EN == 1) begin : g_dbg
      always_comb begin
         unique case (dbg_sel)
            2'd0:    dbg_word = r0_w;
            2'd1:    dbg_word = r1_w;
            2'd2:    dbg_word = r2_w;
            default: dbg_word = {{(WIDTH-1){1'b0}}, carry_q};
         endcase
      end
   end else begin : g_nodbg
      assign dbg_word = '0;
   end
endmodule

// File: rtl/serial_alu3_chk.sv
module serial_alu3_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             step,
   input logic             wr_en,
   input logic [1:0]       dst,
   input logic             carry,
   input logic [WIDTH-1:0] r0,
   input logic [WIDTH-1:0] r1,
   input logic [WIDTH-1:0] r2
);
   localparam int CW = $clog2(WIDTH + 1) + 1;

   logic [CW-1:0] steps_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         steps_seen <= '0;
      end else if (ce && start && !busy) begin
         steps_seen <= CW'(1);
      end else if (step) begin
         steps_seen <= steps_seen + CW'(1);
      end
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(r0) && $stable(r1) && $stable(r2) && $stable(carry) && $stable(done)));

   assert_idle_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !step) |=> (r0 == (($past(r0) >> 1) | ($past(r0) << (WIDTH-1)))));

   assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(carry));

   assert_nondst_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !(wr_en && dst == 2'd1)) |=> (r1 == (($past(r1) >> 1) | ($past(r1) << (WIDTH-1)))));

   assert_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && start && !busy) |=> (busy && !done));

   assert_done_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (steps_seen == CW'(WIDTH)));
endmodule

bind serial_alu3 serial_alu3_chk #(.WIDTH(WIDTH)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ce    (ce),
   .start (start),
   .busy  (busy_w),
   .done  (done),
   .step  (step_w),
   .wr_en (wr_en_w),
   .dst   (dst_w),
   .carry (carry_q),
   .r0    (r0_w),
   .r1    (r1_w),
   .r2    (r2_w)
);

// File: tb/serial_alu3_bench.sv
`timescale 1ns/100ps
module serial_alu3_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ce = 1'b0;
   logic         start = 1'b0;
   logic [2:0]   op = 3'd7;
   logic [1:0]   dst_sel = 2'd0;
   logic         carry_in = 1'b0;
   logic         ser_in = 1'b0;
   logic         ser_out;
   logic         done;
   logic         carry_out;
   logic [1:0]   dbg_sel = 2'd0;
   logic [W-1:0] dbg_word;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // behavioural reference state
   logic [W-1:0] m [3];
   logic         m_c, m_busy, m_done;
   int           m_cnt;
   logic [2:0]   m_op;
   logic [1:0]   m_dst;

   always #2.5 clk = ~clk;

   serial_alu3 #(.WIDTH(W), .DEBUG_EN(1)) u_serial_alu3 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .op(op),
      .dst_sel(dst_sel), .carry_in(carry_in), .ser_in(ser_in),
      .ser_out(ser_out), .done(done), .carry_out(carry_out),
      .dbg_sel(dbg_sel), .dbg_word(dbg_word)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int n);
      logic [W-1:0] t = v;
      for (int i = 0; i < n; i++) t = {t[0], t[W-1:1]};
      return t;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 3; k++) m[k] = '0;
      m_c = 0; m_busy = 0; m_done = 0; m_cnt = 0; m_op = 3'd7; m_dst = 0;
   endtask

   task automatic model_step(input logic e, input logic s, input logic [2:0] o_in,
                             input logic [1:0] d_in, input logic ci, input logic si);
      logic first, act, res, co, cin;
      logic [2:0] o;
      logic [1:0] d;
      int a, b, sum;
      if (!e) return;
      first = s && !m_busy;
      act   = first || m_busy;
      if (!act) begin
         for (int k = 0; k < 3; k++) m[k] = rotr(m[k], 1);
         return;
      end
      if (first) begin m_op = o_in; m_dst = d_in; m_cnt = 0; end
      o = m_op; d = m_dst;
      cin = first ? ci : m_c;
      a = m[0][0]; b = m[1][0];
      co = cin; res = 0;
      case (o)
         3'd0: begin sum = a + b + cin;       res = sum[0]; co = sum[1]; end
         3'd1: begin sum = a + (1 - b) + cin; res = sum[0]; co = sum[1]; end
         3'd2: res = a & b;
         3'd3: res = a | b;
         3'd4: res = a ^ b;
         3'd5: res = a[0];
         3'd6: res = si;
         default: res = 0;
      endcase
      for (int k = 0; k < 3; k++) m[k] = rotr(m[k], 1);
      if (o != 3'd7 && d != 2'd3) m[d][W-1] = res;
      m_c = co;
      m_cnt++;
      if (m_cnt == W) begin m_busy = 0; m_done = 1; end
      else begin m_busy = 1; m_done = 0; end
   endtask

   // compare every port against the reference; called away from the edge
   task automatic compare_all();
      for (int k = 0; k < 4; k++) begin
         dbg_sel = 2'(k);
         #0.2;
         if (k < 3) chk($sformatf("R9 reg%0d", k), dbg_word, m[k]);
         else       chk("R9 carry view", dbg_word, {{(W-1){1'b0}}, m_c});
      end
      chk("R5 done", {{(W-1){1'b0}}, done}, {{(W-1){1'b0}}, m_done});
      chk("R10 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m[2][0]});
      chk("R1 carry_out", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, m_c});
   endtask

   task automatic cyc(input logic e, input logic s, input logic [2:0] o,
                      input logic [1:0] d, input logic ci, input logic si);
      ce = e; start = s; op = o; dst_sel = d; carry_in = ci; ser_in = si;
      @(posedge clk);
      model_step(e, s, o, d, ci, si);
      @(negedge clk);
      compare_all();
   endtask

   task automatic run_op(input logic [2:0] o, input logic [1:0] d, input logic ci,
                         input logic [W-1:0] sv, input int gap_at, input int inj_at);
      for (int i = 0; i < W; i++) begin
         if (i == gap_at)
            for (int g = 0; g < 3; g++) cyc(1'b0, 1'b1, 3'd1, 2'd1, 1'b0, 1'b0);
         if (i == inj_at) cyc(1'b1, 1'b1, 3'd1, 2'd1, ~ci, sv[i]);
         else             cyc(1'b1, i == 0, o, d, ci, sv[i]);
      end
      cyc(1'b0, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic load(input logic [1:0] d, input logic [W-1:0] v);
      run_op(3'd6, d, 1'b0, v, -1, -1);
   endtask

   task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
      dbg_sel = s;
      #0.2;
      v = dbg_word;
   endtask

   task automatic expect_word(input string tag, input logic [1:0] s, input logic [W-1:0] exp);
      logic [W-1:0] v;
      rd(s, v);
      chk(tag, v, exp);
   endtask

   task automatic expect_bit(input string tag, input logic act, input logic exp);
      chk(tag, {{(W-1){1'b0}}, act}, {{(W-1){1'b0}}, exp});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL R5 watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      compare_all();  // R11 reset state
      expect_word("R11 reg2 after reset", 2'd2, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 wrap corner
      load(2'd0, 8'hFF); load(2'd1, 8'h01);
      expect_word("R3 load reg0", 2'd0, 8'hFF);
      run_op(3'd0, 2'd2, 1'b0, '0, -1, -1);
      expect_word("R1 add FF+01", 2'd2, 8'h00);
      expect_bit("R1 add carry", carry_out, 1'b1);
      expect_bit("R5 done held", done, 1'b1);
      expect_word("R4 reg0 restored", 2'd0, 8'hFF);
      expect_word("R4 reg1 restored", 2'd1, 8'h01);

      load(2'd0, 8'h35); load(2'd1, 8'h4A);
      run_op(3'd0, 2'd2, 1'b1, '0, -1, -1);
      expect_word("R1 add 35+4A+1", 2'd2, 8'h80);
      expect_bit("R1 add no carry", carry_out, 1'b0);

      // R2 subtract
      load(2'd0, 8'h10); load(2'd1, 8'h20);
      run_op(3'd1, 2'd2, 1'b1, '0, -1, -1);
      expect_word("R2 sub 10-20", 2'd2, 8'hF0);
      expect_bit("R2 borrow", carry_out, 1'b0);
      load(2'd1, 8'h10);
      run_op(3'd1, 2'd2, 1'b1, '0, -1, -1);
      expect_word("R2 sub equal", 2'd2, 8'h00);
      expect_bit("R2 no borrow", carry_out, 1'b1);

      // R3 logic ops
      load(2'd0, 8'hC3); load(2'd1, 8'h5A);
      run_op(3'd2, 2'd2, 1'b0, '0, -1, -1);
      expect_word("R3 and", 2'd2, 8'h42);
      run_op(3'd3, 2'd2, 1'b0, '0, -1, -1);
      expect_word("R3 or", 2'd2, 8'hDB);
      run_op(3'd4, 2'd2, 1'b1, '0, -1, -1);
      expect_word("R3 xor", 2'd2, 8'h99);
      expect_bit("R3 carry passes", carry_out, 1'b1);
      run_op(3'd5, 2'd2, 1'b0, '0, -1, -1);
      expect_word("R3 pass", 2'd2, 8'hC3);
      run_op(3'd7, 2'd2, 1'b0, 8'hFF, -1, -1);
      expect_word("R3 nop keeps reg2", 2'd2, 8'hC3);
      run_op(3'd6, 2'd3, 1'b0, 8'h55, -1, -1);
      expect_word("R3 dst3 reg0", 2'd0, 8'hC3);
      expect_word("R3 dst3 reg1", 2'd1, 8'h5A);
      expect_word("R3 dst3 reg2", 2'd2, 8'hC3);

      // R6 + R8: in-place add with enable gap and stray start
      run_op(3'd0, 2'd0, 1'b0, '0, 4, 2);
      expect_word("R6 R8 add in place", 2'd0, 8'h1D);
      expect_bit("R8 carry", carry_out, 1'b1);
      expect_word("R4 reg1 kept", 2'd1, 8'h5A);

      // R7 idle rotation then realignment
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0);
      expect_word("R7 rotated by 3", 2'd0, rotr(8'h1D, 3));
      expect_bit("R7 carry held", carry_out, 1'b1);
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0);
      expect_word("R7 realigned", 2'd0, 8'h1D);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule